// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Bank

This block holds three independent 32-bit down-counters behind a word-addressed register bus. Each channel is programmed with an interval, a tick source, a power-of-two prescale and a mode. Once enabled, it counts down by one on every prescaled tick. When it runs out, it flags a pending bit in a shared status register. A continuous channel then restarts from its interval. A single-shot channel parks at zero and turns itself off.

Clock sources are not modelled as clocks. Three single-cycle tick-enable inputs stand in for a slow oscillator, a fast oscillator and a divided PLL. A shared enable mask selects which pending bits drive the single interrupt line. Software clears a pending bit by writing a one to it.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: The byte offsets are: 0x00 interrupt enable mask, 0x04 pending status, and for channel n the control word at 0x10+0x10·n, the interval at 0x14+0x10·n and the read-only count at 0x18+0x10·n. Reads of any other offset return zero, and writes to a count offset are ignored.
- R3: The control word fields are:
  - bit 0: enable
  - bit 1: reload strobe
  - bits 3:2: tick source
  - bits 6:4: prescale code
  - bit 7: mode (0 continuous, 1 single-shot)
- R4: A control write with bit 1 set copies the interval into the count on that clock edge. Bit 1 reads back as 0 one clock later.
- R5: While enabled, the count drops by one on each prescaled tick. While disabled, it holds.
- R6: Tick source 0 selects `tick_slow`, 1 selects `tick_fast` and 2 selects `tick_pll`. Source 3 yields no ticks.
- R7: With prescale code k, one prescaled tick is taken for every 2^k selected ticks. The first one comes on the 2^k-th tick after the channel was enabled from the disabled state.
- R8: A prescaled tick that finds the count at 1 or 0 is an expiry. It sets status bit n. In continuous mode the count reloads the interval, so an interval of N gives an expiry every N prescaled ticks.
- R9: In single-shot mode an expiry leaves the count at 0 and clears the enable bit. Further ticks change neither the count nor the status.
- R10: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R11: `irq` is high exactly when some channel has both its status bit and its enable-mask bit set.
- R12: If an expiry and a clearing write to the same status bit fall in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; `rdata` is zero when low |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| tick_slow | input | 1 | Slow-oscillator tick enable |
| tick_fast | input | 1 | Fast-oscillator tick enable |
| tick_pll | input | 1 | Divided-PLL tick enable |
| irq | output | 1 | Combined interrupt |

## Verification
Two functions can act on the same cycle: a channel's expiry, which sets its pending bit, and a software write that clears that bit. The bench creates the overlap by first counting a continuous channel down to 1. It then raises the fast tick on the same clock as a status write carrying a one for that channel. The result passes only if the status bit still reads 1 and the count has reloaded the interval. A later plain clearing write must then drop both the bit and `irq`.

// File: rtl/tick_timer_bank.sv
module tick_timer_bank #(
  parameter int NCH = 3,
  parameter int DW  = 32,
  parameter int AW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          tick_slow,
  input  logic          tick_fast,
  input  logic          tick_pll,
  output logic          irq
);
  localparam int PW = 7;
  localparam logic [AW-1:0] IER_A = AW'(0);
  localparam logic [AW-1:0] STS_A = AW'(4);

  logic [NCH-1:0]          ier_q, sts_q, expire;
  logic [NCH-1:0][7:0]     ctrl_q;
  logic [NCH-1:0][DW-1:0]  ivl_q, cnt_q;
  logic [NCH-1:0][PW-1:0]  pre_q;
  logic [DW-1:0]           rd_mux;

  wire wr_ier = wr_en && addr == IER_A;
  wire wr_sts = wr_en && addr == STS_A;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ier_q <= '0;
      sts_q <= '0;
    end else begin
      if (wr_ier) ier_q <= wdata[NCH-1:0];
      sts_q <= (sts_q & ~(wr_sts ? wdata[NCH-1:0] : '0)) | expire;
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    localparam logic [AW-1:0] BASE = AW'(16 * (n + 1));
    logic          src_tick;
    logic [PW-1:0] mask;
    logic          ptick;
    wire sel_ctl = wr_en && addr == BASE;
    wire sel_ivl = wr_en && addr == BASE + AW'(4);

    always_comb begin
      case (ctrl_q[n][3:2])
        2'd0:    src_tick = tick_slow;
        2'd1:    src_tick = tick_fast;
        2'd2:    src_tick = tick_pll;
        default: src_tick = 1'b0;
      endcase
    end

    assign mask      = (PW'(1) << ctrl_q[n][6:4]) - PW'(1);
    assign ptick     = ctrl_q[n][0] && src_tick && ((pre_q[n] & mask) == mask);
    assign expire[n] = ptick && cnt_q[n] <= DW'(1);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctrl_q[n] <= '0;
        ivl_q[n]  <= '0;
        cnt_q[n]  <= '0;
        pre_q[n]  <= '0;
      end else begin
        if (!ctrl_q[n][0])  pre_q[n] <= '0;
        else if (src_tick)  pre_q[n] <= pre_q[n] + PW'(1);

        if (sel_ctl) ctrl_q[n] <= wdata[7:0];
        else begin
          ctrl_q[n][1] <= 1'b0;
          if (expire[n] && ctrl_q[n][7]) ctrl_q[n][0] <= 1'b0;
        end

        if (sel_ivl) ivl_q[n] <= wdata;

        if (sel_ctl && wdata[1]) cnt_q[n] <= ivl_q[n];
        else if (ptick)
          cnt_q[n] <= expire[n] ? (ctrl_q[n][7] ? '0 : ivl_q[n]) : cnt_q[n] - DW'(1);
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == IER_A) rd_mux = DW'(ier_q);
    if (addr == STS_A) rd_mux = DW'(sts_q);
    for (int n = 0; n < NCH; n++) begin
      if (addr == AW'(16 * (n + 1)))     rd_mux = DW'(ctrl_q[n]);
      if (addr == AW'(16 * (n + 1) + 4)) rd_mux = ivl_q[n];
      if (addr == AW'(16 * (n + 1) + 8)) rd_mux = cnt_q[n];
    end
  end

  assign rdata = rd_en ? rd_mux : '0;
  assign irq   = |(ier_q & sts_q);
endmodule

// File: rtl/tick_timer_bank_chk.sv
module tick_timer_bank_chk #(
  parameter int NCH = 3,
  parameter int DW  = 32,
  parameter int AW  = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic                   rd_en,
  input logic [AW-1:0]          addr,
  input logic [DW-1:0]          wdata,
  input logic [DW-1:0]          rdata,
  input logic                   irq,
  input logic [NCH-1:0]         ier_q,
  input logic [NCH-1:0]         sts_q,
  input logic [NCH-1:0][7:0]    ctrl_q,
  input logic [NCH-1:0][DW-1:0] cnt_q
);
  // R2
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr[AW-1:3] == '0 && addr[2:0] != 3'd0 && addr[2:0] != 3'd4) |-> rdata == '0);

  // R11
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_q == '0) |-> !irq);

  for (genvar i = 0; i < NCH; i++) begin : g_c
    localparam logic [AW-1:0] CA = AW'(16 * (i + 1));

    // R10
    sts_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sts_q[i]) |-> $past(wr_en && addr == AW'(4) && wdata[i]));

    // R4
    reload_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[i][1] |=> (!ctrl_q[i][1] || $past(wr_en && addr == CA && wdata[1])));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[i][0] && !wr_en) |=> $stable(cnt_q[i]));

    // R9
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ctrl_q[i][0]) && !$past(wr_en && addr == CA)) |-> (cnt_q[i] == '0 && sts_q[i]));
  end
endmodule

bind tick_timer_bank tick_timer_bank_chk #(.NCH(NCH), .DW(DW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .irq(irq), .ier_q(ier_q), .sts_q(sts_q),
  .ctrl_q(ctrl_q), .cnt_q(cnt_q)
);

// File: tb/tick_timer_bank_tb_top.sv
module tick_timer_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tick_slow = 1'b0, tick_fast = 1'b0, tick_pll = 1'b0;
  logic        irq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  tick_timer_bank dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tick_slow(tick_slow), .tick_fast(tick_fast),
    .tick_pll(tick_pll), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 chk(req, rdata, exp);
    rd_en = 1'b0;
  endtask

  // src bit0 slow, bit1 fast, bit2 pll
  task automatic ticks(input logic [2:0] src, input int m);
    @(negedge clk); {tick_pll, tick_fast, tick_slow} = src;
    repeat (m) @(negedge clk);
    {tick_pll, tick_fast, tick_slow} = 3'b000;
  endtask

  task automatic t_reset;
    rd_chk("R1 ier", 8'h00, 0);
    rd_chk("R1 sts", 8'h04, 0);
    rd_chk("R1 ctrl0", 8'h10, 0);
    rd_chk("R1 ivl0", 8'h14, 0);
    rd_chk("R1 cnt2", 8'h38, 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_reload_count;
    wr(8'h14, 10);
    wr(8'h10, 32'h07);
    rd_chk("R4 reload copies interval", 8'h18, 10);
    rd_chk("R4 R3 reload bit self-clears", 8'h10, 32'h05);
    ticks(3'b010, 4);
    rd_chk("R5 decrement per tick", 8'h18, 6);
    ticks(3'b101, 5);
    rd_chk("R6 unselected sources ignored", 8'h18, 6);
  endtask

  task automatic t_continuous;
    ticks(3'b010, 6);
    rd_chk("R8 status set on expiry", 8'h04, 1);
    rd_chk("R8 continuous reload", 8'h18, 10);
    chk("R11 irq masked", 32'(irq), 0);
    wr(8'h00, 1);
    chk("R11 irq when enabled", 32'(irq), 1);
  endtask

  task automatic t_w1c;
    wr(8'h04, 0);
    rd_chk("R10 write zero keeps", 8'h04, 1);
    wr(8'h04, 1);
    rd_chk("R10 write one clears", 8'h04, 0);
    chk("R11 irq drops", 32'(irq), 0);
    wr(8'h10, 32'h04);
    ticks(3'b010, 3);
    rd_chk("R5 disabled holds", 8'h18, 10);
  endtask

  task automatic t_single_shot;
    wr(8'h24, 3);
    wr(8'h20, 32'h8B);
    ticks(3'b100, 3);
    rd_chk("R9 single-shot count zero", 8'h28, 0);
    rd_chk("R9 single-shot enable cleared", 8'h20, 32'h88);
    rd_chk("R8 status bit1", 8'h04, 2);
    chk("R11 irq unmasked bit only", 32'(irq), 0);
    wr(8'h04, 2);
    ticks(3'b100, 4);
    rd_chk("R9 stopped count holds", 8'h28, 0);
    rd_chk("R9 no new status", 8'h04, 0);
    wr(8'h20, 32'h83);
    ticks(3'b001, 1);
    rd_chk("R6 slow source", 8'h28, 2);
    wr(8'h20, 32'h00);
  endtask

  task automatic t_prescale;
    wr(8'h34, 100);
    wr(8'h30, 32'h27);
    ticks(3'b010, 3);
    rd_chk("R7 no tick before 2^k", 8'h38, 100);
    ticks(3'b010, 1);
    rd_chk("R7 first prescaled tick", 8'h38, 99);
    ticks(3'b010, 4);
    rd_chk("R7 second prescaled tick", 8'h38, 98);
    wr(8'h30, 32'h04);
    wr(8'h30, 32'h77);
    ticks(3'b010, 127);
    rd_chk("R7 divide by 128 boundary", 8'h38, 100);
    ticks(3'b010, 1);
    rd_chk("R7 divide by 128 tick", 8'h38, 99);
  endtask

  task automatic t_reserved_src;
    wr(8'h30, 32'h0F);
    ticks(3'b111, 5);
    rd_chk("R6 source 3 no ticks", 8'h38, 100);
    rd_chk("R3 ctrl fields read back", 8'h30, 32'h0D);
  endtask

  task automatic t_map;
    wr(8'h18, 32'h55);
    rd_chk("R2 count write ignored", 8'h18, 10);
    rd_chk("R2 unmapped 0x08", 8'h08, 0);
    rd_chk("R2 unmapped 0x0C", 8'h0C, 0);
    rd_chk("R2 unmapped 0x1C", 8'h1C, 0);
    rd_chk("R2 unmapped 0x40", 8'h40, 0);
  endtask

  task automatic t_collision;
    wr(8'h14, 3);
    wr(8'h10, 32'h07);
    ticks(3'b010, 3);
    rd_chk("R8 expiry before collision", 8'h04, 1);
    ticks(3'b010, 2);
    rd_chk("R5 count at one", 8'h18, 1);
    @(negedge clk);
    tick_fast = 1'b1; wr_en = 1'b1; addr = 8'h04; wdata = 1;
    @(negedge clk);
    tick_fast = 1'b0; wr_en = 1'b0; wdata = 0;
    rd_chk("R12 set wins over clear", 8'h04, 1);
    rd_chk("R12 reload on colliding expiry", 8'h18, 3);
    wr(8'h04, 1);
    rd_chk("R10 later clear", 8'h04, 0);
    chk("R11 irq low after clear", 32'(irq), 0);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_reload_count;
    t_continuous;
    t_w1c;
    t_single_shot;
    t_prescale;
    t_reserved_src;
    t_map;
    t_collision;
    done = 1'b1;
    summary;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1-timeout actual=running expected=finished");
      summary;
    end
  end
endmodule